// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of level-sensitive interrupt requests from peripherals and decides which one, if any, the processor should take next. Every source carries its own 4-bit priority, and the controller holds a running level that belongs to the code currently executing. A request is raised to the processor only when the best pending source outranks that running level strictly and the global enable is on. Along with the request line, the block presents the handler slot address: an aligned table base plus sixteen bytes per source number.

Software programs source priorities, the table base, the running level and the global enable through a simple write port. When the processor takes the interrupt, it pulses an acknowledge. The controller then saves the running level on a 16-deep last-in-first-out stack and raises the level to the priority of the source being serviced. An end-of-interrupt pulse restores the saved level. Request flags stay in the peripherals. A source that is still asserted is therefore offered again once the level drops below its priority.

Top module: `pvic_top`

## Requirements
- R1: After reset, the interrupt output is low, the running level is 15, every source priority is 0 and the global enable is off. A pending request therefore raises nothing until software changes these.
- R2: The interrupt output is high only when the global enable is on and the highest pending source priority is strictly greater than the running level. A source whose priority equals the level is held back.
- R3: Among pending sources, the highest priority is selected. When priorities are equal, the lower source number wins.
- R4: The vector output equals the table base, with its low 11 bits forced to zero, plus 16 times the selected source number. For example, source 62 with base 0x10000 gives 0x103E0.
- R5: The interrupt output and the vector are registered. A change on the request inputs appears after the next rising edge, and a register write appears after the second rising edge.
- R6: An acknowledge while the interrupt output is high pushes the running level and loads the priority of the presented source. An acknowledge while the output is low has no effect.
- R7: An end-of-interrupt restores the most recently saved level. An end-of-interrupt with an empty stack leaves the running level unchanged.
- R8: A request that stays asserted is presented again as soon as the running level falls below its priority.
- R9: Write selects: regSel 0 writes the priority of source regIdx from data[3:0]; 1 writes the table base from data[31:0]; 2 writes the running level from data[3:0]; 3 writes the global enable from data[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Level-sensitive request per source |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (see R9) |
| regIdx | input | SRC_W | Source number for priority writes |
| regWrData | input | ADDR_W | Write data |
| ackStb | input | 1 | Processor takes the presented interrupt |
| eoiStb | input | 1 | Processor finished a handler |
| irqOut | output | 1 | Interrupt request to the processor |
| vecAddr | output | ADDR_W | Handler slot address |
| runLevel | output | PRIO_W | Current running level |

## Verification
A request change reaches irqOut and vecAddr after one rising edge. A register write takes two rising edges, one to store the value and one to register the new decision. An acknowledge or end-of-interrupt updates runLevel at the first edge, and the interrupt line follows at the second. The bench drives every input on the falling edge and waits exactly that number of falling edges before it samples. It also makes one check just before the edge, to confirm that nothing shows early.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {
    SEL_PRIO  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_GIE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrPrio;
    logic wrBase;
    logic wrLevel;
    logic wrGie;
    logic push;
    logic pop;
  } ctlStrobe_t;
endpackage

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int NUM_SRC = 308,
  parameter int PRIO_W  = 4,
  parameter int SRC_W   = 9
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic                      bestValid,
  output logic [PRIO_W-1:0]         bestPrio,
  output logic [SRC_W-1:0]          bestIdx
);
  // Ascending scan with strict compare keeps the lower number on ties.
  always_comb begin
    bestValid = 1'b0;
    bestPrio  = '0;
    bestIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!bestValid || prioFlat[i*PRIO_W +: PRIO_W] > bestPrio)) begin
        bestValid = 1'b1;
        bestPrio  = prioFlat[i*PRIO_W +: PRIO_W];
        bestIdx   = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvic_ctl.sv
module pvic_ctl
  import pvic_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic       ackStb,
  input  logic       eoiStb,
  input  logic       irqOut,
  input  logic       stackEmpty,
  output ctlStrobe_t stb
);
  always_comb begin
    stb.push    = ackStb && irqOut;
    stb.pop     = eoiStb && !ackStb && !stackEmpty;
    stb.wrPrio  = regWrEn && (regSel == SEL_PRIO);
    stb.wrBase  = regWrEn && (regSel == SEL_BASE);
    stb.wrGie   = regWrEn && (regSel == SEL_GIE);
    stb.wrLevel = regWrEn && (regSel == SEL_LEVEL) && !stb.push && !stb.pop;
  end
endmodule

// File: rtl/pvic_dp.sv
module pvic_dp
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 308,
  parameter int PRIO_W      = 4,
  parameter int SRC_W       = 9,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BITS  = 11,
  parameter int SLOT_SHIFT  = 4,
  parameter int STACK_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [SRC_W-1:0]   regIdx,
  input  logic [ADDR_W-1:0]  regWrData,
  output logic               irqQ,
  output logic [ADDR_W-1:0]  vecQ,
  output logic [PRIO_W-1:0]  levelQ,
  output logic [PRIO_W-1:0]  presPrioQ,
  output logic               gieQ,
  output logic               bestValid,
  output logic [PRIO_W-1:0]  bestPrio,
  output logic               stackEmpty
);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int PTR_W = $clog2(STACK_DEPTH + 1);

  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [ADDR_W-1:0]         baseQ;
  logic [SRC_W-1:0]          bestIdx;
  logic [PRIO_W-1:0]         stackMem [STACK_DEPTH];
  logic [PTR_W-1:0]          ptrQ;
  logic [PTR_W-1:0]          ptrDec;
  logic                      stackFull;
  logic [ADDR_W-1:0]         vecNext;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN)
        prioFlat[g*PRIO_W +: PRIO_W] <= '0;
      else if (stb.wrPrio && regIdx == SRC_W'(g))
        prioFlat[g*PRIO_W +: PRIO_W] <= regWrData[PRIO_W-1:0];
    end
  end

  pvic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) arb_i (
    .req(irqReq), .prioFlat(prioFlat),
    .bestValid(bestValid), .bestPrio(bestPrio), .bestIdx(bestIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      gieQ  <= 1'b0;
    end else begin
      if (stb.wrBase) baseQ <= {regWrData[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (stb.wrGie)  gieQ  <= regWrData[0];
    end
  end

  assign stackFull  = (ptrQ == PTR_W'(STACK_DEPTH));
  assign stackEmpty = (ptrQ == '0);
  assign ptrDec     = ptrQ - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '1;
      ptrQ   <= '0;
    end else if (stb.push) begin
      levelQ <= presPrioQ;
      if (!stackFull) ptrQ <= ptrQ + PTR_W'(1);
    end else if (stb.pop) begin
      levelQ <= stackMem[ptrDec[IDX_W-1:0]];
      ptrQ   <= ptrDec;
    end else if (stb.wrLevel) begin
      levelQ <= regWrData[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stackFull) stackMem[ptrQ[IDX_W-1:0]] <= levelQ;
  end

  assign vecNext = baseQ + ADDR_W'({bestIdx, {SLOT_SHIFT{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ      <= 1'b0;
      vecQ      <= '0;
      presPrioQ <= '0;
    end else begin
      irqQ      <= gieQ && bestValid && (bestPrio > levelQ);
      vecQ      <= vecNext;
      presPrioQ <= bestPrio;
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 308,
  parameter int PRIO_W      = 4,
  parameter int SRC_W       = 9,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BITS  = 11,
  parameter int SLOT_SHIFT  = 4,
  parameter int STACK_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [SRC_W-1:0]   regIdx,
  input  logic [ADDR_W-1:0]  regWrData,
  input  logic               ackStb,
  input  logic               eoiStb,
  output logic               irqOut,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [PRIO_W-1:0]  runLevel
);
  ctlStrobe_t        stb;
  logic              stackEmpty;
  logic              gieQ;
  logic              bestValid;
  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] presPrio;

  pvic_ctl ctl_i (
    .regWrEn(regWrEn), .regSel(regSel), .ackStb(ackStb), .eoiStb(eoiStb),
    .irqOut(irqOut), .stackEmpty(stackEmpty), .stb(stb)
  );

  pvic_dp #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W),
    .ALIGN_BITS(ALIGN_BITS), .SLOT_SHIFT(SLOT_SHIFT), .STACK_DEPTH(STACK_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .irqReq(irqReq), .regIdx(regIdx),
    .regWrData(regWrData), .irqQ(irqOut), .vecQ(vecAddr), .levelQ(runLevel),
    .presPrioQ(presPrio), .gieQ(gieQ), .bestValid(bestValid),
    .bestPrio(bestPrio), .stackEmpty(stackEmpty)
  );
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqOut,
  input logic [ADDR_W-1:0] vecAddr,
  input logic [PRIO_W-1:0] runLevel,
  input logic              ackStb,
  input logic              eoiStb,
  input logic              regWrEn,
  input logic              gieQ,
  input logic              bestValid,
  input logic [PRIO_W-1:0] bestPrio,
  input logic [PRIO_W-1:0] presPrio,
  input logic              stackEmpty
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (runLevel == '1) && !irqOut);

  // R2
  strict_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(gieQ) && $past(bestValid) && ($past(bestPrio) > $past(runLevel)));

  // R4
  slot_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (vecAddr[3:0] == 4'd0));

  // R6
  ack_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqOut) |=> (runLevel == $past(presPrio)));

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && !irqOut && !eoiStb && !regWrEn) |=> $stable(runLevel));

  // R7
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStb && !ackStb && stackEmpty && !regWrEn) |=> $stable(runLevel));
endmodule

bind pvic_top pvic_chk #(.PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .vecAddr(vecAddr),
  .runLevel(runLevel), .ackStb(ackStb), .eoiStb(eoiStb), .regWrEn(regWrEn),
  .gieQ(gieQ), .bestValid(bestValid), .bestPrio(bestPrio),
  .presPrio(presPrio), .stackEmpty(stackEmpty)
);

// File: tb/pvic_tb.sv
`timescale 1ns/100ps
module pvic_top_tb_top;
  localparam int NUM_SRC = 308;
  localparam int SRC_W   = 9;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] irqReq = '0;
  logic               regWrEn = 1'b0;
  logic [1:0]         regSel = '0;
  logic [SRC_W-1:0]   regIdx = '0;
  logic [31:0]        regWrData = '0;
  logic               ackStb = 1'b0;
  logic               eoiStb = 1'b0;
  logic               irqOut;
  logic [31:0]        vecAddr;
  logic [3:0]         runLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pvic_top dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regWrEn(regWrEn), .regSel(regSel),
    .regIdx(regIdx), .regWrData(regWrData), .ackStb(ackStb), .eoiStb(eoiStb),
    .irqOut(irqOut), .vecAddr(vecAddr), .runLevel(runLevel)
  );

  typedef struct packed {
    logic [8:0]  src;
    logic [3:0]  prio;
    logic [3:0]  lvl;
    logic [31:0] base;
    logic        expIrq;
    logic [31:0] expVec;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{9'd62,  4'd5,  4'd0,  32'h0001_0000, 1'b1, 32'h0001_03E0},
    '{9'd0,   4'd15, 4'd14, 32'h0000_0000, 1'b1, 32'h0000_0000},
    '{9'd307, 4'd3,  4'd3,  32'h0000_0000, 1'b0, 32'h0000_0000},
    '{9'd307, 4'd4,  4'd3,  32'h1234_5678, 1'b1, 32'h1234_6330},
    '{9'd10,  4'd7,  4'd9,  32'h0000_0000, 1'b0, 32'h0000_0000},
    '{9'd100, 4'd1,  4'd0,  32'h0000_0800, 1'b1, 32'h0000_0E40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input int idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regIdx = SRC_W'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); ackStb = 1'b1;
    @(negedge clk); ackStb = 1'b0;
  endtask

  task automatic pulseEoi();
    @(negedge clk); eoiStb = 1'b1;
    @(negedge clk); eoiStb = 1'b0;
  endtask

  initial begin
    irqReq[3] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irq after reset", {31'd0, irqOut}, 32'd0);
    check("R1 level after reset", {28'd0, runLevel}, 32'd15);

    // R9 selects: level (2) then enable (3); source 3 still at priority 0
    wr(2'd2, 0, 32'd0);
    wr(2'd3, 0, 32'd1);
    @(negedge clk);
    check("R1 R2 priority 0 never fires", {31'd0, irqOut}, 32'd0);
    irqReq = '0;

    for (int i = 0; i < 6; i++) begin
      wr(2'd0, int'(TBL[i].src), {28'd0, TBL[i].prio});
      wr(2'd1, 0, TBL[i].base);
      wr(2'd2, 0, {28'd0, TBL[i].lvl});
      irqReq[TBL[i].src] = 1'b1;
      #1;
      check("R5 no early output", {31'd0, irqOut}, 32'd0);
      @(negedge clk);
      check("R2 R9 table irq", {31'd0, irqOut}, {31'd0, TBL[i].expIrq});
      if (TBL[i].expIrq) check("R4 table vector", vecAddr, TBL[i].expVec);
      irqReq = '0;
      @(negedge clk);
    end

    // R3 ties and ordering
    wr(2'd1, 0, 32'h2000);
    wr(2'd0, 5, 32'd6);
    wr(2'd0, 9, 32'd6);
    wr(2'd2, 0, 32'd0);
    irqReq[5] = 1'b1; irqReq[9] = 1'b1;
    @(negedge clk);
    check("R3 tie lower number", vecAddr, 32'h2050);
    irqReq[5] = 1'b0;
    @(negedge clk);
    check("R3 remaining source", vecAddr, 32'h2090);
    wr(2'd0, 20, 32'd8);
    irqReq[5] = 1'b1; irqReq[20] = 1'b1;
    @(negedge clk);
    check("R3 higher priority wins", vecAddr, 32'h2140);

    // R2 global enable gating, R5 two-edge latency of a write
    wr(2'd3, 0, 32'd0);
    check("R5 write not yet visible", {31'd0, irqOut}, 32'd1);
    @(negedge clk);
    check("R2 enable off", {31'd0, irqOut}, 32'd0);
    wr(2'd3, 0, 32'd1);
    @(negedge clk);
    check("R2 enable on", {31'd0, irqOut}, 32'd1);

    // R6 acknowledge
    pulseAck();
    check("R6 ack loads priority", {28'd0, runLevel}, 32'd8);
    @(negedge clk);
    check("R6 irq drops after ack", {31'd0, irqOut}, 32'd0);
    pulseAck();
    check("R6 ack ignored when idle", {28'd0, runLevel}, 32'd8);

    // Nesting, R7 restore, R8 re-presentation
    wr(2'd0, 30, 32'd12);
    irqReq[30] = 1'b1;
    @(negedge clk);
    check("R2 nested irq", {31'd0, irqOut}, 32'd1);
    check("R4 nested vector", vecAddr, 32'h21E0);
    pulseAck();
    check("R6 nested level", {28'd0, runLevel}, 32'd12);
    pulseEoi();
    check("R7 restore outer", {28'd0, runLevel}, 32'd8);
    @(negedge clk);
    check("R8 held request again", {31'd0, irqOut}, 32'd1);
    irqReq[30] = 1'b0;
    pulseEoi();
    check("R7 restore base", {28'd0, runLevel}, 32'd0);
    @(negedge clk);
    check("R8 source 20 again", vecAddr, 32'h2140);
    pulseEoi();
    check("R7 empty pop no effect", {28'd0, runLevel}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule